// File: doc/BRIEF.md
# Series-Exponential Sigmoid and Tanh Unit

This block evaluates either the logistic sigmoid or the hyperbolic tangent of one signed 16-bit fixed-point argument in Q4.12 format (12 fractional bits). A request is a one-cycle `start` pulse carrying the argument and a function select. The unit then runs its own sequence and raises `done` for exactly one cycle. The result stays on `result` until a later evaluation overwrites it.

No lookup table is used. The unit builds an exponential from a cubic power series, using a single shared multiplier over four cycles. It then forms the activation with one restoring division that yields one quotient bit per cycle. Two steps keep the series in the range where it is accurate. First, the argument is clamped so that only magnitudes up to 2.0 reach the series, and anything larger saturates at once. Second, the series is always evaluated on a non-negative exponent, and the sign of the argument is restored at the end through the symmetry of each function.

The state machine has nine named states:
- `S_IDLE` waits for `start`. It goes to `S_DONE` for a clamped argument and to `S_SQR` otherwise.
- `S_SQR` forms v², then moves to `S_CUBE`.
- `S_CUBE` forms v³, then moves to `S_HALF`.
- `S_HALF` forms v²/2, then moves to `S_SIXTH`.
- `S_SIXTH` forms v³/6, then moves to `S_SUM`.
- `S_SUM` adds the terms and loads the divider, then moves to `S_DIV`.
- `S_DIV` stays until the last quotient bit is produced, then moves to `S_SIGN`.
- `S_SIGN` applies the sign symmetry, then moves to `S_DONE`.
- `S_DONE` pulses `done`, then returns to `S_IDLE`.

Top module: `series_act`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: `start` is accepted only in `S_IDLE`, where `x_in` and `mode` are captured. Mode value 0 selects sigmoid and mode value 1 selects tanh.
- R3: An argument above 8192 (2.0) or below -8192 saturates, with no series evaluation. Sigmoid gives 4096 above the range and 0 below it. Tanh gives 4096 above the range and -4096 below it.
- R4: For |x| ≤ 8192, let a = |x|, with v = a for sigmoid and v = 2a for tanh. Then p2 = floor(v·v/4096), p3 = floor(p2·v/4096), t2 = floor(p2·2048/4096), t3 = floor(p3·683/4096), and E = 4096 + v + t2 + t3.
- R5: For sigmoid in range, q = floor(E·4096/(E+4096)). The result is q when x ≥ 0 and 4096 − q when x < 0.
- R6: For tanh in range, q = floor((E−4096)·4096/(E+4096)). The result is q when x ≥ 0 and −q when x < 0.
- R7: Count the cycle in which `start` is sampled as cycle 0. `done` is high in cycle 1 for a saturated argument and in cycle 19 for an in-range argument.
- R8: `done` is high for exactly one cycle per evaluation.
- R9: `result` holds its value from the `done` cycle until a later accepted `start`.
- R10: A `start` pulse that arrives while an evaluation is running has no effect on that evaluation's result or its timing.
- R11: The bounds ±8192 are evaluated by the series (R4 to R6), not saturated.
- R12: sigmoid(x) + sigmoid(−x) = 4096 and tanh(−x) = −tanh(x) for every in-range x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request, accepted in `S_IDLE` |
| mode | input | 1 | Function select: 0 sigmoid, 1 tanh |
| x_in | input | 16 | Signed Q4.12 argument |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Signed Q4.12 activation, held between evaluations |

## Verification
Directed arguments cover several distinct behaviours:
- Zero exposes the midpoint of each function.
- The values ±8192 and ±8193 separate the series path from the saturated path, both in the result and in the latency.
- The extremes ±32767 and −32768 check that the magnitude never wraps.

Paired arguments x and −x in both modes show whether the sign symmetry is applied correctly. Seeded random arguments, mostly inside the clamp window, compare each result bit-exactly against the series-and-division model. In some of these runs a second `start` with a different argument and mode arrives mid-evaluation, and both the result and the timing must be unchanged by it.

// File: rtl/act_pkg.sv
package act_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SQR,
        S_CUBE,
        S_HALF,
        S_SIXTH,
        S_SUM,
        S_DIV,
        S_SIGN,
        S_DONE
    } act_state_t;

    localparam logic MODE_SIG  = 1'b0;
    localparam logic MODE_TANH = 1'b1;

endpackage

// File: rtl/act_range.sv
module act_range #(
    parameter int WIDTH = 16,
    parameter int FRAC  = 12,
    parameter int EXT_W = 20
) (
    input  logic signed [WIDTH-1:0] x,
    input  logic                    tanh_sel,
    output logic                    sat,
    output logic                    neg,
    output logic [EXT_W-1:0]        mag,
    output logic signed [WIDTH-1:0] sat_val
);
    localparam int ONE = 1 << FRAC;
    localparam int LIM = 2 << FRAC;

    logic signed [WIDTH:0] x_ext;
    logic        [WIDTH:0] x_abs;

    always_comb begin
        x_ext = (WIDTH+1)'(x);
        neg   = x[WIDTH-1];
        x_abs = neg ? (WIDTH+1)'(-x_ext) : (WIDTH+1)'(x_ext);
        sat   = (int'(x) > LIM) || (int'(x) < -LIM);
        if (tanh_sel) begin
            mag = EXT_W'(x_abs) << 1;
        end else begin
            mag = EXT_W'(x_abs);
        end
        if (!neg) begin
            sat_val = WIDTH'(ONE);
        end else if (tanh_sel) begin
            sat_val = WIDTH'(-ONE);
        end else begin
            sat_val = '0;
        end
    end
endmodule

// File: rtl/act_mul.sv
module act_mul #(
    parameter int AW   = 20,
    parameter int BW   = 16,
    parameter int FRAC = 12
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [AW-1:0] p
);
    localparam int PW = AW + BW;

    logic [PW-1:0] full;

    always_comb begin
        full = {{BW{1'b0}}, a} * {{AW{1'b0}}, b};
        p    = full[FRAC +: AW];
    end
endmodule

// File: rtl/act_div.sv
module act_div #(
    parameter int DW = 20,
    parameter int QW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          last
);
    localparam int CW = $clog2(QW + 1);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic [DW-1:0] rem_sh;
    logic          fits;

    always_comb begin
        rem_sh = {rem_q[DW-2:0], 1'b0};
        fits   = rem_sh >= den_q;
        last   = active_q && (cnt_q == CW'(QW - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            den_q    <= '0;
            cnt_q    <= '0;
            quo      <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            rem_q    <= num;
            den_q    <= den;
            cnt_q    <= '0;
            quo      <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            rem_q <= fits ? (rem_sh - den_q) : rem_sh;
            quo   <= {quo[QW-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/series_act.sv
module series_act #(
    parameter int WIDTH = 16,
    parameter int FRAC  = 12,
    parameter int EXT_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    mode,
    input  logic signed [WIDTH-1:0] x_in,
    output logic                    done,
    output logic signed [WIDTH-1:0] result
);
    import act_pkg::*;

    localparam int ONE   = 1 << FRAC;
    localparam int HALF  = 1 << (FRAC - 1);
    localparam int SIXTH = (ONE + 3) / 6;

    act_state_t state_q, state_d;

    logic                    rng_sat, rng_neg;
    logic [EXT_W-1:0]        rng_mag;
    logic signed [WIDTH-1:0] rng_sat_val;

    logic                    mode_q, neg_q;
    logic [EXT_W-1:0]        v_q, v2_q, v3_q, t2_q, t3_q;
    logic signed [WIDTH-1:0] res_q;

    logic [EXT_W-1:0]        mul_a, mul_p;
    logic [WIDTH-1:0]        mul_b;

    logic [EXT_W-1:0]        e_sum, div_num, div_den;
    logic                    div_load, div_last;
    logic [FRAC-1:0]         div_quo;
    logic signed [WIDTH-1:0] q_s, signed_res;

    act_range #(.WIDTH(WIDTH), .FRAC(FRAC), .EXT_W(EXT_W)) u_range (
        .x        (x_in),
        .tanh_sel (mode),
        .sat      (rng_sat),
        .neg      (rng_neg),
        .mag      (rng_mag),
        .sat_val  (rng_sat_val)
    );

    act_mul #(.AW(EXT_W), .BW(WIDTH), .FRAC(FRAC)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (mul_p)
    );

    act_div #(.DW(EXT_W), .QW(FRAC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .last  (div_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = rng_sat ? S_DONE : S_SQR;
            S_SQR:   state_d = S_CUBE;
            S_CUBE:  state_d = S_HALF;
            S_HALF:  state_d = S_SIXTH;
            S_SIXTH: state_d = S_SUM;
            S_SUM:   state_d = S_DIV;
            S_DIV:   if (div_last) state_d = S_SIGN;
            S_SIGN:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Shared multiplier operand selection
    always_comb begin
        mul_a = v_q;
        mul_b = WIDTH'(v_q);
        unique case (state_q)
            S_CUBE:  begin mul_a = v2_q; mul_b = WIDTH'(v_q);  end
            S_HALF:  begin mul_a = v2_q; mul_b = WIDTH'(HALF);  end
            S_SIXTH: begin mul_a = v3_q; mul_b = WIDTH'(SIXTH); end
            default: begin mul_a = v_q;  mul_b = WIDTH'(v_q);  end
        endcase
    end

    // Series sum, division operands, sign restoration
    always_comb begin
        e_sum    = EXT_W'(ONE) + v_q + t2_q + t3_q;
        div_num  = (mode_q == MODE_TANH) ? (e_sum - EXT_W'(ONE)) : e_sum;
        div_den  = e_sum + EXT_W'(ONE);
        div_load = (state_q == S_SUM);
        q_s      = WIDTH'(div_quo);
        if (mode_q == MODE_TANH) begin
            signed_res = neg_q ? -q_s : q_s;
        end else begin
            signed_res = neg_q ? (WIDTH'(ONE) - q_s) : q_s;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SIG;
            neg_q  <= 1'b0;
            v_q    <= '0;
            v2_q   <= '0;
            v3_q   <= '0;
            t2_q   <= '0;
            t3_q   <= '0;
            res_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        neg_q  <= rng_neg;
                        v_q    <= rng_mag;
                        if (rng_sat) begin
                            res_q <= rng_sat_val;
                        end
                    end
                end
                S_SQR:   v2_q  <= mul_p;
                S_CUBE:  v3_q  <= mul_p;
                S_HALF:  t2_q  <= mul_p;
                S_SIXTH: t3_q  <= mul_p;
                S_SIGN:  res_q <= signed_res;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done   = (state_q == S_DONE);
        result = res_q;
    end
endmodule

// File: rtl/act_checker.sv
module act_checker #(
    parameter int WIDTH = 16,
    parameter int FRAC  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    done,
    input logic signed [WIDTH-1:0] result,
    input act_pkg::act_state_t     state,
    input logic                    mode_q
);
    import act_pkg::*;

    localparam int ONE = 1 << FRAC;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> $stable(result));

    a_r3_result_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(result) <= ONE && int'(result) >= -ONE));

    a_r5_sigmoid_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_SIG) |-> (int'(result) >= 0));

    a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(mode_q));

    a_r7_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == S_SIGN || $past(state) == S_IDLE));
endmodule

bind series_act act_checker #(.WIDTH(WIDTH), .FRAC(FRAC)) u_act_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (state_q),
    .mode_q (mode_q)
);

// File: tb/tb_series_act.sv
module tb_series_act;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;
    localparam int LAT_SERIES = 19;
    localparam int LAT_SAT    = 1;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic               mode;
    logic signed [15:0] x_in;
    logic               done;
    logic signed [15:0] result;

    int n_chk = 0;
    int n_bad = 0;

    series_act dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .x_in   (x_in),
        .done   (done),
        .result (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected values from R3..R6
    function automatic int model(input int x, input bit m);
        longint a, v, p2, p3, t2, t3, e, num, den, q;
        if (x > 8192)  return 4096;
        if (x < -8192) return m ? -4096 : 0;
        a  = (x < 0) ? -x : x;
        v  = m ? 2 * a : a;
        p2 = (v * v) / 4096;
        p3 = (p2 * v) / 4096;
        t2 = (p2 * 2048) / 4096;
        t3 = (p3 * 683) / 4096;
        e  = 4096 + v + t2 + t3;
        num = m ? e - 4096 : e;
        den = e + 4096;
        q   = (num * 4096) / den;
        if (x >= 0) return int'(q);
        return m ? int'(-q) : int'(4096 - q);
    endfunction

    task automatic run(input int x, input bit m, input bit poke, output int res);
        int lat;
        int exp_res;
        int exp_lat;
        exp_res = model(x, m);
        exp_lat = (x > 8192 || x < -8192) ? LAT_SAT : LAT_SERIES;
        @(negedge clk);
        start = 1'b1;
        x_in  = 16'(x);
        mode  = m;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 100) begin
            if (poke && lat == 3) begin
                start = 1'b1;
                x_in  = 16'sd100;
                mode  = ~m;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = int'(result);
        check($sformatf("R4 R5 R6 value x=%0d mode=%0d", x, m), res, exp_res);
        check($sformatf("R7 latency x=%0d", x), lat, exp_lat);
        @(negedge clk);
        check("R8 done single pulse", int'(done), 0);
        repeat (2) @(negedge clk);
        check("R9 result held", int'(result), exp_res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r, rn, x;
        bit m;
        void'($urandom(SEED));
        rst_n = 1'b0;
        start = 1'b0;
        mode  = 1'b0;
        x_in  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset done", int'(done), 0);
        check("R1 reset result", int'(result), 0);

        // R5 R6 midpoint
        run(0, 1'b0, 1'b0, r);
        check("R5 sigmoid(0)", r, 2048);
        run(0, 1'b1, 1'b0, r);
        check("R6 tanh(0)", r, 0);

        // R11 bounds on series path, R3 just outside
        for (int mm = 0; mm < 2; mm++) begin
            run(8192, bit'(mm), 1'b0, r);
            run(-8192, bit'(mm), 1'b0, r);
            run(8193, bit'(mm), 1'b0, r);
            check("R3 saturate high", r, 4096);
            run(-8193, bit'(mm), 1'b0, r);
            check("R3 saturate low", r, mm ? -4096 : 0);
            run(32767, bit'(mm), 1'b0, r);
            run(-32768, bit'(mm), 1'b0, r);
            check("R3 extreme low", r, mm ? -4096 : 0);
        end

        // R12 symmetry
        for (int i = 0; i < 8; i++) begin
            x = int'($urandom_range(0, 8192));
            run(x, 1'b0, 1'b0, r);
            run(-x, 1'b0, 1'b0, rn);
            check("R12 sigmoid symmetry", r + rn, 4096);
            run(x, 1'b1, 1'b0, r);
            run(-x, 1'b1, 1'b0, rn);
            check("R12 tanh odd", r + rn, 0);
        end

        // R10 start during an evaluation ignored
        run(3000, 1'b0, 1'b1, r);
        run(-5000, 1'b1, 1'b1, r);

        // R2 random mix
        for (int i = 0; i < 250; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                x = int'($urandom_range(0, 65535)) - 32768;
            end else begin
                x = int'($urandom_range(0, 18000)) - 9000;
            end
            m = bit'($urandom_range(0, 1));
            run(x, m, bit'($urandom_range(0, 3) == 0), r);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule